// File: doc/BRIEF.md
# Status Channel Sync Monitor

This block decides whether the received flow-control status channel is in frame synchronization. An upstream status-frame decoder reports one result per received frame: a strobe that marks the end of the frame, and two error flags, one for a bad framing word and one for a failed DIP-2 parity check. The monitor counts clean frames in a row and the errors seen since the last clean frame. It compares those counts with two 4-bit thresholds that can be set at runtime, one to acquire sync and one to lose it.

The sync flag has hysteresis. It rises only after enough consecutive clean frames. It falls only after enough errors since the last clean frame. A single clean frame clears the error tally, and a single errored frame clears the clean-run tally. Both tallies are brought out as 4-bit debug counters.

Top module: `stat_sync_mon`

## Requirements
- R1: After reset, inSync is 0 and both goodCount and badCount are 0.
- R2: A frame reported with frameDone=1, frameErr=0 and dipErr=0 is clean. It increments goodCount and sets badCount to 0. The new values appear on the cycle after the strobe.
- R3: A frame reported with frameDone=1 and either frameErr=1 or dipErr=1 is errored. It increments badCount and sets goodCount to 0. The new values appear on the cycle after the strobe.
- R4: A frame with both frameErr=1 and dipErr=1 counts as exactly one error.
- R5: While out of sync, inSync goes to 1 on the cycle after the clean frame that brings the consecutive clean count up to the acquire threshold.
- R6: While in sync, inSync goes to 0 on the cycle after the errored frame that brings the error count since the last clean frame up to the lose threshold.
- R7: A threshold value of 0 behaves exactly like a value of 1.
- R8: When frameDone is 0, the outputs do not change, whatever the error flags and thresholds are.
- R9: Both thresholds are sampled only on the cycle that frameDone is 1. They may change freely between frames.
- R10: goodCount and badCount stop at 15 and do not wrap to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameDone | input | 1 | One-cycle strobe at the end of each status frame |
| frameErr | input | 1 | Framing error for the frame (valid with frameDone) |
| dipErr | input | 1 | DIP-2 error for the frame (valid with frameDone) |
| acqThresh | input | 4 | Number of consecutive clean frames needed to gain sync (0 means 1) |
| loseThresh | input | 4 | Number of errors since the last clean frame needed to drop sync (0 means 1) |
| inSync | output | 1 | Status channel is in frame sync |
| goodCount | output | 4 | Consecutive clean frames, saturating |
| badCount | output | 4 | Errors since the last clean frame, saturating |

## Verification
The bench aims at the edges of each threshold. It checks that sync rises on the frame that meets the acquire threshold and not on the one before it, so a design that compared with the wrong bound would switch one frame early or late. It places a clean frame between errors to show that the error tally restarts; a design that needed consecutive bad frames, or that never cleared the tally, would drop sync at the wrong time. It also drives zero thresholds, frames that carry both error flags, long runs that hit saturation, and error flags or threshold changes with no strobe present. These expose a design that stalls when a threshold is zero, counts a double-flagged frame twice, wraps a counter back to 0, or reacts to inputs between frames.

// File: rtl/stat_sync_pkg.sv
package stat_sync_pkg;

  typedef struct packed {
    logic incGood;
    logic clrGood;
    logic incBad;
    logic clrBad;
  } cntStrobe_t;

  typedef enum logic {
    SYNC_LOST = 1'b0,
    SYNC_HELD = 1'b1
  } syncState_t;

endpackage

// File: rtl/stat_sync_satcnt.sv
module stat_sync_satcnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] CntMax = '1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (inc && count != CntMax) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/stat_sync_dp.sv
module stat_sync_dp
  import stat_sync_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  output logic [CNT_W-1:0] goodCount,
  output logic [CNT_W-1:0] badCount
);
  stat_sync_satcnt #(.W(CNT_W)) u_goodCnt (
    .clk   (clk),
    .rstN  (rstN),
    .inc   (strobe.incGood),
    .clr   (strobe.clrGood),
    .count (goodCount)
  );

  stat_sync_satcnt #(.W(CNT_W)) u_badCnt (
    .clk   (clk),
    .rstN  (rstN),
    .inc   (strobe.incBad),
    .clr   (strobe.clrBad),
    .count (badCount)
  );
endmodule

// File: rtl/stat_sync_ctrl.sv
module stat_sync_ctrl
  import stat_sync_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameDone,
  input  logic             frameErr,
  input  logic             dipErr,
  input  logic [CNT_W-1:0] acqThresh,
  input  logic [CNT_W-1:0] loseThresh,
  input  logic [CNT_W-1:0] goodCount,
  input  logic [CNT_W-1:0] badCount,
  output cntStrobe_t       strobe,
  output logic             inSync
);
  localparam int EW = CNT_W + 1;

  syncState_t state, stateNext;
  logic          frameBad, frameClean;
  logic [EW-1:0] effAcq, effLose, goodPlus, badPlus;
  logic          acqHit, loseHit;

  // one errored frame, however many flags it carries
  assign frameBad   = frameDone & (frameErr | dipErr);
  assign frameClean = frameDone & ~(frameErr | dipErr);

  // zero threshold behaves like one
  assign effAcq  = (acqThresh  == '0) ? EW'(1) : {1'b0, acqThresh};
  assign effLose = (loseThresh == '0) ? EW'(1) : {1'b0, loseThresh};

  assign goodPlus = {1'b0, goodCount} + EW'(1);
  assign badPlus  = {1'b0, badCount}  + EW'(1);
  assign acqHit   = goodPlus >= effAcq;
  assign loseHit  = badPlus  >= effLose;

  always_comb begin
    strobe.incGood = frameClean;
    strobe.clrGood = frameBad;
    strobe.incBad  = frameBad;
    strobe.clrBad  = frameClean;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      SYNC_LOST: if (frameClean && acqHit) stateNext = SYNC_HELD;
      SYNC_HELD: if (frameBad && loseHit)  stateNext = SYNC_LOST;
      default:   stateNext = SYNC_LOST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SYNC_LOST;
    else       state <= stateNext;
  end

  assign inSync = (state == SYNC_HELD);
endmodule

// File: rtl/stat_sync_mon.sv
module stat_sync_mon
  import stat_sync_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameDone,
  input  logic             frameErr,
  input  logic             dipErr,
  input  logic [CNT_W-1:0] acqThresh,
  input  logic [CNT_W-1:0] loseThresh,
  output logic             inSync,
  output logic [CNT_W-1:0] goodCount,
  output logic [CNT_W-1:0] badCount
);
  cntStrobe_t strobe;

  stat_sync_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameDone  (frameDone),
    .frameErr   (frameErr),
    .dipErr     (dipErr),
    .acqThresh  (acqThresh),
    .loseThresh (loseThresh),
    .goodCount  (goodCount),
    .badCount   (badCount),
    .strobe     (strobe),
    .inSync     (inSync)
  );

  stat_sync_dp #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .goodCount (goodCount),
    .badCount  (badCount)
  );
endmodule

// File: rtl/stat_sync_mon_chk.sv
module stat_sync_mon_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameDone,
  input logic             frameErr,
  input logic             dipErr,
  input logic [CNT_W-1:0] acqThresh,
  input logic [CNT_W-1:0] loseThresh,
  input logic             inSync,
  input logic [CNT_W-1:0] goodCount,
  input logic [CNT_W-1:0] badCount
);
  localparam logic [CNT_W-1:0] CntMax = '1;
  logic anyErr;
  assign anyErr = frameErr | dipErr;

  AST_CLEAN_CLEARS_BAD: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && !anyErr |=> badCount == '0); // R2
  AST_ERR_CLEARS_GOOD: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && anyErr |=> goodCount == '0); // R3
  AST_DOUBLE_ONE_ERR: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && frameErr && dipErr && badCount != CntMax
    |=> badCount == $past(badCount) + 1'b1); // R4
  AST_RISE_ON_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inSync) |-> $past(frameDone && !anyErr)); // R5
  AST_FALL_ON_ERR: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inSync) |-> $past(frameDone && anyErr)); // R6
  AST_ZERO_ACQ: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && !anyErr && acqThresh == '0 |=> inSync); // R7
  AST_ZERO_LOSE: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && anyErr && loseThresh == '0 |=> !inSync); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !frameDone |=> $stable(inSync) && $stable(goodCount) && $stable(badCount)); // R8
  AST_NO_WRAP_GOOD: assert property (@(posedge clk) disable iff (!rstN)
    goodCount == CntMax && frameDone && !anyErr |=> goodCount == CntMax); // R10
  AST_NO_WRAP_BAD: assert property (@(posedge clk) disable iff (!rstN)
    badCount == CntMax && frameDone && anyErr |=> badCount == CntMax); // R10
endmodule

bind stat_sync_mon stat_sync_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .frameDone  (frameDone),
  .frameErr   (frameErr),
  .dipErr     (dipErr),
  .acqThresh  (acqThresh),
  .loseThresh (loseThresh),
  .inSync     (inSync),
  .goodCount  (goodCount),
  .badCount   (badCount)
);

// File: tb/stat_sync_mon_bench.sv
module stat_sync_mon_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameDone = 1'b0, frameErr = 1'b0, dipErr = 1'b0;
  logic [3:0] acqThresh = 4'd0, loseThresh = 4'd0;
  logic       inSync;
  logic [3:0] goodCount, badCount;

  int vecCount = 0;
  int errCount = 0;
  int cycles = 0;

  logic       mSync = 1'b0;
  logic [3:0] mGood = 4'd0, mBad = 4'd0;

  stat_sync_mon u_stat_sync_mon (
    .clk(clk), .rstN(rstN), .frameDone(frameDone), .frameErr(frameErr),
    .dipErr(dipErr), .acqThresh(acqThresh), .loseThresh(loseThresh),
    .inSync(inSync), .goodCount(goodCount), .badCount(badCount)
  );

  always #10 clk = ~clk;

  function automatic logic [3:0] eff(input logic [3:0] t);
    return (t == 4'd0) ? 4'd1 : t;
  endfunction

  function automatic logic [3:0] satInc(input logic [3:0] v);
    return (v == 4'hF) ? v : v + 4'd1;
  endfunction

  task automatic finish();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errCount++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 100000", cycles);
      finish();
    end
  end

  task automatic check(input string req);
    vecCount++;
    if (inSync !== mSync || goodCount !== mGood || badCount !== mBad) begin
      errCount++;
      $display("FAIL %s: actual sync=%0b good=%0d bad=%0d expected sync=%0b good=%0d bad=%0d",
               req, inSync, goodCount, badCount, mSync, mGood, mBad);
    end
  endtask

  // drive at negedge, model updates at posedge, compare at next negedge
  task automatic step(input logic d, input logic fe, input logic de,
                      input logic [3:0] acq, input logic [3:0] lose, input string req);
    frameDone = d; frameErr = fe; dipErr = de; acqThresh = acq; loseThresh = lose;
    @(posedge clk);
    if (d) begin
      if (!(fe || de)) begin
        if (!mSync && satInc(mGood) >= eff(acq)) mSync = 1'b1;
        mGood = satInc(mGood);
        mBad  = 4'd0;
      end else begin
        if (mSync && satInc(mBad) >= eff(lose)) mSync = 1'b0;
        mBad  = satInc(mBad);
        mGood = 4'd0;
      end
    end
    @(negedge clk);
    frameDone = 1'b0;
    check(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1");
    rstN = 1'b1;
    @(negedge clk);
    check("R1");

    // acquire with threshold 3: must not rise after two clean frames
    step(1, 0, 0, 4'd3, 4'd2, "R2");
    step(1, 0, 0, 4'd3, 4'd2, "R5");
    step(1, 0, 0, 4'd3, 4'd2, "R5");
    // error flags without strobe are ignored
    step(0, 1, 1, 4'd0, 4'd0, "R8");
    step(0, 1, 0, 4'd0, 4'd0, "R8");
    // lose threshold 2, clean frame in between restarts tally
    step(1, 1, 0, 4'd3, 4'd2, "R3");
    step(1, 0, 0, 4'd3, 4'd2, "R6");
    step(1, 0, 1, 4'd3, 4'd2, "R6");
    step(1, 1, 1, 4'd3, 4'd2, "R6");
    // double flag counts once
    step(1, 1, 1, 4'd3, 4'd9, "R4");
    // zero thresholds
    step(1, 0, 0, 4'd0, 4'd0, "R7");
    step(1, 1, 0, 4'd0, 4'd0, "R7");
    // saturation
    for (int i = 0; i < 20; i++) step(1, 0, 0, 4'd15, 4'd15, "R10");
    for (int i = 0; i < 20; i++) step(1, 0, 1, 4'd15, 4'd15, "R10");
    // thresholds change between frames; only strobe cycle value counts
    step(1, 0, 0, 4'd2, 4'd1, "R9");
    step(0, 0, 0, 4'd1, 4'd1, "R9");
    step(1, 0, 0, 4'd2, 4'd1, "R9");

    void'($urandom(32'h5EED_1234));
    for (int n = 0; n < 4000; n++) begin
      logic d, fe, de;
      logic [3:0] a, l;
      d  = ($urandom % 4) != 0;
      fe = ($urandom % 5) == 0;
      de = ($urandom % 5) == 0;
      a  = 4'($urandom % 6);
      l  = 4'($urandom % 6);
      if (($urandom % 16) == 0) begin a = 4'($urandom); l = 4'($urandom); end
      step(d, fe, de, a, l, !d ? "R8" : (fe && de) ? "R4" : (fe || de) ? "R6" : "R5");
    end
    finish();
  end
endmodule